// File: doc/BRIEF.md
# Nonvolatile Array Write-Protection Gate

This block sits between the serial-bus front end of a small byte-addressed nonvolatile memory and its array write port. When the bus layer has collected a complete write (a start address plus up to one page of buffered bytes, or a lock command) and sees the closing stop, it raises a commit request. The block then runs the internally timed programming cycle and, for each buffered byte, decides whether that byte may actually be written. A blocked write still takes the full cycle, so the bus side sees identical busy timing whether data landed or not.

Two protection sources are combined. An external protect pin, sampled when the commit is accepted, blocks every address while it is high. A one-time software lock, set by a dedicated lock command while the pin is low, blocks only the lower half of the array (address MSB equal to 0) and can never be cleared by normal operation. The lock bit is kept out of the functional reset to model its retention across power loss; only a separate blank-device clear input returns it to zero. The pad driving the protect pin is expected to carry a pull-down, so a floating pin reads as low. The lock state is also brought out so the bus layer can refuse to acknowledge a second lock command.

Top module: `wp_ctrl`

## Requirements
- R1: With the lock set and the protect pin low at acceptance, no byte whose address has MSB 0 (00h to 7Fh) is written, while bytes with MSB 1 (80h to FFh) are written.
- R2: With the protect pin high at acceptance, no byte is written at any address, whether the lock is set or not.
- R3: With the protect pin low and the lock clear, every buffered byte is written.
- R4: A lock command (`cmd_kind` = 1) accepted with the pin low and the lock clear raises `prot_set` for exactly one cycle, the first cycle after acceptance, and `sw_locked` reads 1 from the cycle after that; with the pin high there is no strobe and the lock stays 0. Address and length of a lock command are ignored.
- R5: Once set, `sw_locked` stays 1 through any later command and through `rst_n`; only `fresh_n` low clears it.
- R6: An array command (`cmd_kind` = 0) presents byte i (i = 0 .. n-1, n = min(`cmd_len`,16)) in the (i+1)-th cycle after acceptance at an address whose upper 4 bits equal those of `cmd_addr` and whose lower 4 bits are (`cmd_addr`[3:0] + i) mod 16.
- R7: `busy` is 1 for exactly TWR_CYC cycles starting the cycle after every accepted command, whether or not anything was written.
- R8: `cmd_valid` while `busy` is 1 is ignored: no extra cycle, no write, no strobe.
- R9: The protect pin is sampled only when a command is accepted; changing it during the cycle has no effect on that command.
- R10: A lock command while the lock is already set gives no strobe but still holds `busy` for the full cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous assert, synchronous release |
| fresh_n | input | 1 | Blank-device clear of the lock bit, active low, asynchronous |
| wp_pin | input | 1 | External protect pin, 1 = whole array protected |
| cmd_valid | input | 1 | Commit request at the closing stop of a write |
| cmd_kind | input | 1 | 0 = array write, 1 = lock command |
| cmd_addr | input | 8 | Address of the first buffered byte |
| cmd_len | input | 5 | Number of buffered bytes (values above 16 act as 16) |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Gated write enable for the array |
| arr_addr | output | 8 | Address of the byte being written, valid with `arr_we` |
| arr_idx | output | 4 | Buffer index of the byte being written |
| prot_set | output | 1 | One-cycle strobe that programs the lock |
| sw_locked | output | 1 | Current lock state |

## Verification
The bench goes after the boundary between the halves (7Fh versus 80h), page wrap-around inside a page, and the interplay of pin and lock: a design that compared the wrong address bit would block or pass the wrong half, and one that carried the page index into the upper bits would write into a neighbouring page. It issues lock commands with the pin high, twice in a row, and after a functional reset; a design that set the lock under the pin, strobed again, or cleared the bit on reset would show a wrong `prot_set` or `sw_locked`. Blocked writes and refused lock commands are timed against the full cycle, so a design that shortened the cycle when nothing was written is caught, as is one that accepted a command while busy or re-sampled the pin mid-cycle.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic {
    CMD_ARRAY = 1'b0,
    CMD_LOCK  = 1'b1
  } wp_cmd_e;
endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/wp_lock_bit.sv
// Retained lock flag: only the blank-device clear resets it.
module wp_lock_bit (
  input  logic clk,
  input  logic fresh_n,
  input  logic set_en,
  output logic locked
);
  logic lock_q;
  logic lock_d;

  always_comb begin
    lock_d = lock_q;
    if (set_en) lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge fresh_n) begin
    if (!fresh_n) lock_q <= 1'b0;
    else          lock_q <= lock_d;
  end

  assign locked = lock_q;
endmodule

// File: rtl/wp_gate.sv
// Per-byte permission: pin blocks all, lock blocks the half with MSB 0.
module wp_gate #(
  parameter int ADDR_W = 8
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_held,
  input  logic              locked,
  output logic              we
);
  logic low_half;
  logic lock_hit;

  always_comb begin
    low_half = ~addr[ADDR_W-1];
    lock_hit = locked & low_half;
    we       = req & ~wp_held & ~lock_hit;
  end
endmodule

// File: rtl/wp_seq.sv
module wp_seq
  import wp_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int TWR_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PAGE_W:0]   cmd_len,
  input  logic              wp_pin,
  output logic              busy,
  output logic              first_cyc,
  output logic              byte_req,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [PAGE_W-1:0] byte_idx,
  output wp_cmd_e           kind,
  output logic              wp_held
);
  localparam int LEN_W  = PAGE_W + 1;
  localparam int CNT_W  = $clog2(TWR_CYC);
  localparam int CMP_W  = (CNT_W > LEN_W) ? CNT_W : LEN_W;
  localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1 << PAGE_W);
  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(TWR_CYC - 1);

  logic              busy_q,  busy_d;
  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  wp_cmd_e           kind_q,  kind_d;
  logic [ADDR_W-1:0] base_q,  base_d;
  logic [LEN_W-1:0]  num_q,   num_d;
  logic              wp_q,    wp_d;
  logic              accept;
  logic              cnt_en;
  logic [LEN_W-1:0]  len_clamped;
  logic [PAGE_W-1:0] low_sum;

  always_comb begin
    accept      = cmd_valid & ~busy_q;
    cnt_en      = busy_q;
    len_clamped = (cmd_len > PAGE_BYTES) ? PAGE_BYTES : cmd_len;

    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    base_d = base_q;
    num_d  = num_q;
    wp_d   = wp_q;

    if (cnt_en) begin
      if (cnt_q == LAST_CNT) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end else if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      kind_d = wp_cmd_e'(cmd_kind);
      base_d = cmd_addr;
      num_d  = len_clamped;
      wp_d   = wp_pin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= CMD_ARRAY;
      base_q <= '0;
      num_q  <= '0;
      wp_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      base_q <= base_d;
      num_q  <= num_d;
      wp_q   <= wp_d;
    end
  end

  always_comb begin
    low_sum   = base_q[PAGE_W-1:0] + cnt_q[PAGE_W-1:0];
    byte_addr = {base_q[ADDR_W-1:PAGE_W], low_sum};
    byte_idx  = cnt_q[PAGE_W-1:0];
    byte_req  = busy_q & (kind_q == CMD_ARRAY) & (CMP_W'(cnt_q) < CMP_W'(num_q));
    first_cyc = busy_q & (cnt_q == '0);
  end

  assign busy    = busy_q;
  assign kind    = kind_q;
  assign wp_held = wp_q;
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int TWR_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fresh_n,
  input  logic              wp_pin,
  input  logic              cmd_valid,
  input  logic              cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PAGE_W:0]   cmd_len,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [PAGE_W-1:0] arr_idx,
  output logic              prot_set,
  output logic              sw_locked
);
  logic              rst_sn;
  logic              first_cyc;
  logic              byte_req;
  logic [ADDR_W-1:0] byte_addr;
  logic [PAGE_W-1:0] byte_idx;
  wp_cmd_e           kind;
  logic              wp_held;
  logic              locked;
  logic              set_en;

  wp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  wp_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWR_CYC(TWR_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .wp_pin    (wp_pin),
    .busy      (busy),
    .first_cyc (first_cyc),
    .byte_req  (byte_req),
    .byte_addr (byte_addr),
    .byte_idx  (byte_idx),
    .kind      (kind),
    .wp_held   (wp_held)
  );

  wp_gate #(.ADDR_W(ADDR_W)) u_gate (
    .req     (byte_req),
    .addr    (byte_addr),
    .wp_held (wp_held),
    .locked  (locked),
    .we      (arr_we)
  );

  always_comb begin
    set_en = first_cyc & (kind == CMD_LOCK) & ~wp_held & ~locked;
  end

  wp_lock_bit u_lock (
    .clk     (clk),
    .fresh_n (fresh_n),
    .set_en  (set_en),
    .locked  (locked)
  );

  assign arr_addr  = byte_addr;
  assign arr_idx   = byte_idx;
  assign prot_set  = set_en;
  assign sw_locked = locked;
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk #(
  parameter int ADDR_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int TWR_CYC = 40
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              fresh_n,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              prot_set,
  input logic              sw_locked,
  input logic              wp_held
);
  localparam int CW = $clog2(TWR_CYC + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)   run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  AST_LOCK_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_sn)
    (arr_we && sw_locked) |-> arr_addr[ADDR_W-1]); // R1
  AST_PIN_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_sn)
    wp_held |-> !arr_we); // R2
  AST_SET_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    prot_set |-> (!wp_held && !sw_locked && busy)); // R4
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_sn || !fresh_n)
    prot_set |=> sw_locked); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!fresh_n || !rst_sn)
    $past(sw_locked) |-> sw_locked); // R5
  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rst_sn)
    (arr_we && $past(arr_we) && $past(busy)) |-> (arr_addr[ADDR_W-1:PAGE_W] == $past(arr_addr[ADDR_W-1:PAGE_W]))); // R6
  AST_FULL_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy) |-> (run_q == CW'(TWR_CYC))); // R7
  AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    (arr_we || prot_set) |-> busy); // R7
endmodule

bind wp_ctrl wp_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWR_CYC(TWR_CYC)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .fresh_n   (fresh_n),
  .busy      (busy),
  .arr_we    (arr_we),
  .arr_addr  (arr_addr),
  .prot_set  (prot_set),
  .sw_locked (sw_locked),
  .wp_held   (wp_held)
);

// File: tb/sim_wp_ctrl.sv
`timescale 1ns/1ps
module sim_wp_ctrl;
  localparam int TWR = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fresh_n = 1'b0;
  logic       wp_pin = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_kind = 1'b0;
  logic [7:0] cmd_addr = 8'h00;
  logic [4:0] cmd_len = 5'd0;
  logic       busy, arr_we, prot_set, sw_locked;
  logic [7:0] arr_addr;
  logic [3:0] arr_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string scen = "reset";

  // behavioural reference state
  int m_busy = 0, m_cnt = 0, m_kind = 0, m_base = 0, m_num = 0, m_wp = 0, m_lock = 0;
  int we_count = 0;

  always #4 clk = ~clk;

  wp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fresh_n(fresh_n), .wp_pin(wp_pin),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_idx(arr_idx),
    .prot_set(prot_set), .sw_locked(sw_locked)
  );

  function automatic int exp_set();
    return (m_busy && m_cnt == 0 && m_kind == 1 && !m_wp && !m_lock) ? 1 : 0;
  endfunction

  function automatic int exp_addr();
    return (m_base & 'hF0) | ((m_base + m_cnt) & 'hF);
  endfunction

  function automatic int exp_we();
    int a;
    a = exp_addr();
    if (!(m_busy && m_kind == 0 && m_cnt < m_num)) return 0;
    if (m_wp) return 0;
    if (m_lock && a < 128) return 0;
    return 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] cycle %0d: actual %0h expected %0h", req, scen, cyc, act, exp);
    end
  endtask

  // reference model update
  always @(posedge clk) begin
    int set_now;
    cyc++;
    set_now = exp_set();
    if (exp_we()) we_count++;
    if (!fresh_n) m_lock = 0;
    else if (set_now) m_lock = 1;
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == TWR - 1) begin m_busy = 0; m_cnt = 0; end
      else m_cnt++;
    end else if (cmd_valid) begin
      m_busy = 1; m_cnt = 0; m_kind = cmd_kind; m_base = cmd_addr;
      m_num = (cmd_len > 16) ? 16 : cmd_len; m_wp = wp_pin;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      string wtag;
      wtag = m_wp ? "R2" : (m_lock ? "R1" : "R3");
      chk("R7 busy", busy, m_busy);
      chk("R4 prot_set", prot_set, exp_set());
      chk("R5 sw_locked", sw_locked, m_lock);
      chk({wtag, " arr_we"}, arr_we, exp_we());
      if (exp_we()) begin
        chk("R6 arr_addr", arr_addr, exp_addr());
        chk("R6 arr_idx", arr_idx, m_cnt);
      end
    end
  end

  task automatic issue(input int kind, input int addr, input int len, input int wp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind[0]; cmd_addr = addr[7:0];
    cmd_len = len[4:0]; wp_pin = wp[0];
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run(input int kind, input int addr, input int len, input int wp);
    issue(kind, addr, len, wp);
    idle(TWR + 2);
  endtask

  task automatic count_cmd(input string req, input int kind, input int addr,
                           input int len, input int wp, input int exp_n);
    int start;
    start = we_count;
    run(kind, addr, len, wp);
    chk(req, we_count - start, exp_n);
  endtask

  initial begin
    idle(3);
    scen = "reset state";
    chk("R7 reset busy", busy, 0);
    chk("R5 reset lock", sw_locked, 0);
    fresh_n = 1'b1;
    rst_n = 1'b1;
    idle(4);

    scen = "R3 open page wrap";
    count_cmd("R3 count", 0, 'h3C, 16, 0, 16);
    scen = "R6 short write";
    count_cmd("R6 count", 0, 'h75, 3, 0, 3);
    scen = "R6 length clamp";
    count_cmd("R6 clamp", 0, 'h81, 20, 0, 16);
    scen = "R2 pin high open";
    count_cmd("R2 count", 0, 'h10, 8, 1, 0);
    scen = "R4 lock under pin";
    run(1, 'h55, 1, 1);
    chk("R4 no lock", sw_locked, 0);

    scen = "R8 ignore while busy";
    issue(0, 'h20, 4, 0);
    cmd_valid = 1'b1; cmd_kind = 1'b1;
    idle(5);
    cmd_valid = 1'b0;
    idle(TWR);
    chk("R8 lock untouched", sw_locked, 0);

    scen = "R9 pin toggles mid-cycle";
    issue(0, 'h40, 16, 0);
    wp_pin = 1'b1; idle(6); wp_pin = 1'b0; idle(TWR);
    issue(0, 'h48, 16, 1);
    wp_pin = 1'b0; idle(TWR + 2);

    scen = "R4 lock set";
    run(1, 'hFF, 0, 0);
    chk("R4 locked", sw_locked, 1);
    scen = "R1 lower half boundary";
    count_cmd("R1 low", 0, 'h7F, 1, 0, 0);
    count_cmd("R1 high", 0, 'h80, 1, 0, 1);
    count_cmd("R1 low page", 0, 'h00, 16, 0, 0);
    count_cmd("R1 high page", 0, 'hF8, 16, 0, 16);
    scen = "R2 pin high locked";
    count_cmd("R2 locked", 0, 'hC0, 16, 1, 0);
    scen = "R10 second lock";
    run(1, 'h00, 1, 0);
    chk("R10 still locked", sw_locked, 1);

    scen = "R5 warm reset";
    rst_n = 1'b0; idle(3);
    chk("R5 lock kept", sw_locked, 1);
    rst_n = 1'b1; idle(4);
    count_cmd("R5 low still blocked", 0, 'h30, 4, 0, 0);

    scen = "R5 blank clear";
    fresh_n = 1'b0; idle(2);
    chk("R5 cleared", sw_locked, 0);
    fresh_n = 1'b1; idle(2);
    count_cmd("R3 reopened", 0, 'h30, 4, 0, 4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule